// File: doc/BRIEF.md
# Memory Fence Ordering Gate

This block sits between an in-order stream of memory operations and a memory subsystem that has a store buffer. Each operation arrives on a valid/ready handshake with a 3-bit type code. Loads and stores go to memory in the cycle they are accepted. The block keeps three outstanding counts: loads still waiting for data, stores not yet complete locally, and stores not yet globally visible. It lowers `op_ready` when the ordering rules of the three fence kinds require it. Memory reports progress on three single-cycle pulse inputs.

A full fence and a load fence wait at the head of the stream with `op_ready` low until their drain condition holds. They are consumed in that cycle. A store fence leaves the head at once and waits in a side slot. While it waits, later loads keep flowing and later stores and fences are held. Every fence retirement gives a single-cycle pulse together with the fence kind.

Top module: `mem_fence_gate`

## Requirements
- R1: Type codes are 0 load, 1 store, 2 full fence, 3 store fence, 4 load fence. An accepted load pulses `mem_ld_issue`, and an accepted store pulses `mem_st_issue`, in the same cycle as the handshake (`op_valid && op_ready`).
- R2: A full fence keeps `op_ready` low until no load is awaiting data, no store is awaiting local completion and no store is awaiting global visibility.
- R3: A store fence retires only when no store is awaiting global visibility. While it is pending, a store at the head sees `op_ready` low.
- R4: While a store fence is pending, a load at the head is accepted and issued.
- R5: A load fence keeps `op_ready` low until no load is awaiting data and no store is awaiting local completion. It does not wait for global visibility.
- R6: A fence retires in the same cycle as the completion pulse that drains the last count it waits on.
- R7: Each retirement drives `fence_retire` high for one cycle with `fence_retire_kind` set to the fence's type code (2, 3 or 4).
- R8: While a store fence is pending, any fence at the head (code 2, 3 or 4) sees `op_ready` low.
- R9: Codes 5, 6 and 7 are accepted at once. They issue nothing and change no count.
- R10: A completion or visibility pulse that arrives while its count is zero is ignored, so the count never wraps below zero.
- R11: With CTR_W = 8, a load is held (`op_ready` low) while 255 loads are outstanding. The same limit holds stores on either store count.
- R12: Reset (`rst_n` low) clears all counts and any pending store fence. After reset a full fence retires in its first cycle at the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Head operation is present |
| op_type | input | 3 | Head operation type code |
| op_ready | output | 1 | Head operation is accepted this cycle when valid |
| mem_ld_issue | output | 1 | Load sent to memory this cycle |
| mem_st_issue | output | 1 | Store sent to memory this cycle |
| ld_data_done | input | 1 | One load has returned its data |
| st_local_done | input | 1 | One store has completed locally |
| st_global_vis | input | 1 | One store has become globally visible |
| fence_retire | output | 1 | A fence retires this cycle |
| fence_retire_kind | output | 3 | Type code of the retiring fence |

## Verification
A count that is too low shows up as a fence retiring early. The retire pulse and a raised `op_ready` appear in a cycle where the bench's own count is still non-zero, and this is seen in the first cycle that fence waits at the head. A count that is too high, or a store fence that never leaves its slot, keeps `op_ready` low in the cycle the bench expects it high. Loads that do not bypass a pending store fence, stores that do, and wrapped or saturated counts are all reported as `op_ready` or issue mismatches in the cycle of the handshake concerned.

// File: rtl/fence_gate_pkg.sv
package fence_gate_pkg;

  localparam int unsigned OP_W = 3;

  localparam logic [OP_W-1:0] OP_LOAD        = 3'd0;
  localparam logic [OP_W-1:0] OP_STORE       = 3'd1;
  localparam logic [OP_W-1:0] OP_FULL_FENCE  = 3'd2;
  localparam logic [OP_W-1:0] OP_STORE_FENCE = 3'd3;
  localparam logic [OP_W-1:0] OP_LOAD_FENCE  = 3'd4;

  // Outstanding-count slots
  localparam int unsigned NUM_CTR  = 3;
  localparam int unsigned CTR_LD   = 0;
  localparam int unsigned CTR_SLOC = 1;
  localparam int unsigned CTR_SVIS = 2;

  typedef struct packed {
    logic is_load;
    logic is_store;
    logic is_full;
    logic is_sfence;
    logic is_lfence;
  } op_dec_t;

  function automatic op_dec_t decode_op(logic [OP_W-1:0] code);
    op_dec_t d;
    d.is_load   = (code == OP_LOAD);
    d.is_store  = (code == OP_STORE);
    d.is_full   = (code == OP_FULL_FENCE);
    d.is_sfence = (code == OP_STORE_FENCE);
    d.is_lfence = (code == OP_LOAD_FENCE);
    return d;
  endfunction

endpackage

// File: rtl/fg_rst_sync.sv
module fg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/fg_pend_ctr.sv
module fg_pend_ctr #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] count_o,
  output logic         at_max_o,
  output logic         drains_o
);

  localparam logic [W-1:0] CNT_MAX = '1;
  localparam logic [W-1:0] CNT_ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         dec_ok;
  logic         cnt_en;

  // Next-state: a pulse against an empty count is dropped; the count holds at its limit
  always_comb begin
    dec_ok = dec_i && (cnt_q != '0);
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (inc_i && !dec_ok) begin
      if (cnt_q != CNT_MAX) begin
        cnt_d  = cnt_q + CNT_ONE;
        cnt_en = 1'b1;
      end
    end else if (dec_ok && !inc_i) begin
      cnt_d  = cnt_q - CNT_ONE;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o  = cnt_q;
  assign at_max_o = (cnt_q == CNT_MAX);
  // Empty now, or emptied by the pulse arriving this cycle
  assign drains_o = (cnt_q == '0) || ((cnt_q == CNT_ONE) && dec_i);

endmodule

// File: rtl/fg_order_ctrl.sv
module fg_order_ctrl
  import fence_gate_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid_i,
  input  logic [OP_W-1:0] op_code_i,
  input  logic            ld_drain_i,
  input  logic            sloc_drain_i,
  input  logic            svis_drain_i,
  input  logic            ld_full_i,
  input  logic            sloc_full_i,
  input  logic            svis_full_i,
  output logic            op_ready_o,
  output logic            ld_issue_o,
  output logic            st_issue_o,
  output logic            retire_o,
  output logic [OP_W-1:0] retire_kind_o,
  output logic            sf_pend_o
);

  op_dec_t dec;
  logic    sf_pend_q;
  logic    sf_pend_d;
  logic    sf_pend_en;
  logic    full_ok;
  logic    lfence_ok;
  logic    ready;
  logic    head_fire;
  logic    slot_retire;
  logic    head_retire;

  always_comb begin
    dec       = decode_op(op_code_i);
    full_ok   = ld_drain_i && sloc_drain_i && svis_drain_i;
    lfence_ok = ld_drain_i && sloc_drain_i;

    ready = 1'b1;
    if (dec.is_load) begin
      ready = !ld_full_i;
    end else if (dec.is_store) begin
      ready = !sf_pend_q && !sloc_full_i && !svis_full_i;
    end else if (dec.is_full) begin
      ready = !sf_pend_q && full_ok;
    end else if (dec.is_sfence) begin
      ready = !sf_pend_q;
    end else if (dec.is_lfence) begin
      ready = !sf_pend_q && lfence_ok;
    end

    head_fire   = op_valid_i && ready;
    slot_retire = sf_pend_q && svis_drain_i;
    head_retire = head_fire &&
                  (dec.is_full || dec.is_lfence || (dec.is_sfence && svis_drain_i));

    sf_pend_d  = sf_pend_q;
    sf_pend_en = 1'b0;
    if (slot_retire) begin
      sf_pend_d  = 1'b0;
      sf_pend_en = 1'b1;
    end else if (head_fire && dec.is_sfence && !svis_drain_i) begin
      sf_pend_d  = 1'b1;
      sf_pend_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sf_pend_q <= 1'b0;
    end else if (sf_pend_en) begin
      sf_pend_q <= sf_pend_d;
    end
  end

  assign op_ready_o    = ready;
  assign ld_issue_o    = head_fire && dec.is_load;
  assign st_issue_o    = head_fire && dec.is_store;
  assign retire_o      = slot_retire || head_retire;
  assign retire_kind_o = slot_retire ? OP_STORE_FENCE :
                         (head_retire ? op_code_i : '0);
  assign sf_pend_o     = sf_pend_q;

endmodule

// File: rtl/mem_fence_gate.sv
module mem_fence_gate
  import fence_gate_pkg::*;
#(
  parameter int unsigned CTR_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [OP_W-1:0] op_type,
  output logic            op_ready,
  output logic            mem_ld_issue,
  output logic            mem_st_issue,
  input  logic            ld_data_done,
  input  logic            st_local_done,
  input  logic            st_global_vis,
  output logic            fence_retire,
  output logic [OP_W-1:0] fence_retire_kind
);

  logic               rst_sync_n;
  logic [NUM_CTR-1:0] ctr_inc;
  logic [NUM_CTR-1:0] ctr_dec;
  logic [NUM_CTR-1:0] ctr_full;
  logic [NUM_CTR-1:0] ctr_drain;
  logic [CTR_W-1:0]   ctr_cnt [NUM_CTR];
  logic [CTR_W-1:0]   ld_cnt_w;
  logic [CTR_W-1:0]   sloc_cnt_w;
  logic [CTR_W-1:0]   svis_cnt_w;
  logic               sf_pend_w;

  fg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_sync_n)
  );

  assign ctr_inc[CTR_LD]   = mem_ld_issue;
  assign ctr_inc[CTR_SLOC] = mem_st_issue;
  assign ctr_inc[CTR_SVIS] = mem_st_issue;
  assign ctr_dec[CTR_LD]   = ld_data_done;
  assign ctr_dec[CTR_SLOC] = st_local_done;
  assign ctr_dec[CTR_SVIS] = st_global_vis;

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    fg_pend_ctr #(.W(CTR_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .inc_i    (ctr_inc[g]),
      .dec_i    (ctr_dec[g]),
      .count_o  (ctr_cnt[g]),
      .at_max_o (ctr_full[g]),
      .drains_o (ctr_drain[g])
    );
  end

  fg_order_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .op_valid_i    (op_valid),
    .op_code_i     (op_type),
    .ld_drain_i    (ctr_drain[CTR_LD]),
    .sloc_drain_i  (ctr_drain[CTR_SLOC]),
    .svis_drain_i  (ctr_drain[CTR_SVIS]),
    .ld_full_i     (ctr_full[CTR_LD]),
    .sloc_full_i   (ctr_full[CTR_SLOC]),
    .svis_full_i   (ctr_full[CTR_SVIS]),
    .op_ready_o    (op_ready),
    .ld_issue_o    (mem_ld_issue),
    .st_issue_o    (mem_st_issue),
    .retire_o      (fence_retire),
    .retire_kind_o (fence_retire_kind),
    .sf_pend_o     (sf_pend_w)
  );

  assign ld_cnt_w   = ctr_cnt[CTR_LD];
  assign sloc_cnt_w = ctr_cnt[CTR_SLOC];
  assign svis_cnt_w = ctr_cnt[CTR_SVIS];

endmodule

// File: rtl/mem_fence_gate_chk.sv
module mem_fence_gate_chk #(
  parameter int unsigned CTR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [2:0]       op_type,
  input logic             op_ready,
  input logic             mem_ld_issue,
  input logic             mem_st_issue,
  input logic             fence_retire,
  input logic [2:0]       fence_retire_kind,
  input logic             sf_pend,
  input logic [CTR_W-1:0] ld_cnt,
  input logic [CTR_W-1:0] sloc_cnt,
  input logic [CTR_W-1:0] svis_cnt
);

  a_r1_load_issue_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ld_issue |-> (op_valid && op_ready && op_type == 3'd0));

  a_r2_full_fence_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_retire && fence_retire_kind == 3'd2) |=>
      (ld_cnt == '0 && sloc_cnt == '0 && svis_cnt == '0));

  a_r3_store_fence_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_retire && fence_retire_kind == 3'd3) |=> (svis_cnt == '0));

  a_r3_no_store_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    sf_pend |-> !mem_st_issue);

  a_r5_load_fence_local: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_retire && fence_retire_kind == 3'd4) |=> (ld_cnt == '0 && sloc_cnt == '0));

  a_r7_retire_kind: assert property (@(posedge clk) disable iff (!rst_n)
    fence_retire |-> (fence_retire_kind == 3'd2 || fence_retire_kind == 3'd3 ||
                      fence_retire_kind == 3'd4));

  a_r8_fence_behind_sfence: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_pend && op_valid && (op_type == 3'd2 || op_type == 3'd3 || op_type == 3'd4))
      |-> !op_ready);

  a_r9_nop_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_type > 3'd4) |-> (op_ready && !mem_ld_issue && !mem_st_issue));

  a_r10_no_underflow_ld: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_cnt == '0 && !mem_ld_issue) |=> (ld_cnt == '0));

  a_r10_no_underflow_svis: assert property (@(posedge clk) disable iff (!rst_n)
    (svis_cnt == '0 && !mem_st_issue) |=> (svis_cnt == '0));

  a_r11_hold_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (&ld_cnt) |-> !mem_ld_issue);

endmodule

bind mem_fence_gate mem_fence_gate_chk #(.CTR_W(CTR_W)) i_chk (
  .clk               (clk),
  .rst_n             (rst_sync_n),
  .op_valid          (op_valid),
  .op_type           (op_type),
  .op_ready          (op_ready),
  .mem_ld_issue      (mem_ld_issue),
  .mem_st_issue      (mem_st_issue),
  .fence_retire      (fence_retire),
  .fence_retire_kind (fence_retire_kind),
  .sf_pend           (sf_pend_w),
  .ld_cnt            (ld_cnt_w),
  .sloc_cnt          (sloc_cnt_w),
  .svis_cnt          (svis_cnt_w)
);

// File: tb/test_mem_fence_gate.sv
`timescale 1ns/1ps
module test_mem_fence_gate;

  localparam int CMAX = 255;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [2:0] op_type = 3'd0;
  logic       ld_done = 1'b0;
  logic       st_done = 1'b0;
  logic       st_vis = 1'b0;
  logic       op_ready, mem_ld_issue, mem_st_issue, fence_retire;
  logic [2:0] fence_retire_kind;

  int tests = 0;
  int fails = 0;
  bit live = 0;
  bit calc_ok = 0;
  bit finished = 0;

  // Bench reference model
  int m_ld, m_loc, m_vis;
  bit m_sf;
  bit e_ready, e_sret, e_ret, n_fire;
  int e_kind;
  bit s_ld, s_st, s_vis;
  int s_type;

  mem_fence_gate i_mem_fence_gate (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_type(op_type),
    .op_ready(op_ready), .mem_ld_issue(mem_ld_issue), .mem_st_issue(mem_st_issue),
    .ld_data_done(ld_done), .st_local_done(st_done), .st_global_vis(st_vis),
    .fence_retire(fence_retire), .fence_retire_kind(fence_retire_kind)
  );

  always #2 clk = ~clk;

  function automatic bit drains(int c, bit p);
    return (c == 0) || (c == 1 && p);
  endfunction

  function automatic string ready_tag(int t, bit sf);
    case (t)
      0: return sf ? "R4" : "R11";
      1: return sf ? "R3" : "R1";
      2: return sf ? "R8" : "R2";
      3: return sf ? "R8" : "R3";
      4: return sf ? "R8" : "R5";
      default: return "R9";
    endcase
  endfunction

  function automatic int pick_type();
    int r;
    r = int'($urandom % 16);
    if (r < 6) return 0;
    if (r < 11 || r == 15) return 1;
    if (r == 11) return 2;
    if (r == 12) return 3;
    if (r == 13) return 4;
    return 5 + int'($urandom % 3);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ld = 0; m_loc = 0; m_vis = 0; m_sf = 0; n_fire = 0; calc_ok = 0;
  endtask

  // Per-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    if (live) begin
      #1;
      s_ld = ld_done; s_st = st_done; s_vis = st_vis; s_type = int'(op_type);
      case (s_type)
        0: e_ready = (m_ld < CMAX);
        1: e_ready = !m_sf && m_loc < CMAX && m_vis < CMAX;
        2: e_ready = !m_sf && drains(m_ld, s_ld) && drains(m_loc, s_st) && drains(m_vis, s_vis);
        3: e_ready = !m_sf;
        4: e_ready = !m_sf && drains(m_ld, s_ld) && drains(m_loc, s_st);
        default: e_ready = 1'b1;
      endcase
      n_fire = op_valid && e_ready;
      e_sret = m_sf && drains(m_vis, s_vis);
      e_ret  = e_sret || (n_fire && (s_type == 2 || s_type == 4 ||
                                     (s_type == 3 && drains(m_vis, s_vis))));
      e_kind = e_sret ? 3 : s_type;
      if (op_valid)
        chk(op_ready == e_ready, ready_tag(s_type, m_sf), "op_ready", int'(op_ready), int'(e_ready));
      chk(mem_ld_issue == (n_fire && s_type == 0), "R1", "mem_ld_issue",
          int'(mem_ld_issue), int'(n_fire && s_type == 0));
      chk(mem_st_issue == (n_fire && s_type == 1), "R1", "mem_st_issue",
          int'(mem_st_issue), int'(n_fire && s_type == 1));
      chk(fence_retire == e_ret, (s_ld || s_st || s_vis) ? "R6" : "R7", "fence_retire",
          int'(fence_retire), int'(e_ret));
      if (e_ret)
        chk(int'(fence_retire_kind) == e_kind, "R7", "fence_retire_kind",
            int'(fence_retire_kind), e_kind);
      calc_ok = 1;
    end
  end

  always @(posedge clk) begin
    if (live && calc_ok) begin
      if (e_sret) m_sf = 0;
      else if (n_fire && s_type == 3 && !drains(m_vis, s_vis)) m_sf = 1;
      m_ld  = m_ld  + int'(n_fire && s_type == 0) - int'(s_ld  && m_ld  > 0);
      m_loc = m_loc + int'(n_fire && s_type == 1) - int'(s_st  && m_loc > 0);
      m_vis = m_vis + int'(n_fire && s_type == 1) - int'(s_vis && m_vis > 0);
    end
  end

  task automatic step(input bit v, input int t, input bit l, input bit s, input bit g);
    @(negedge clk);
    op_valid = v; op_type = 3'(t); ld_done = l; st_done = s; st_vis = g;
    #1.2;
  endtask

  task automatic drain();
    while (m_ld > 0 || m_loc > 0 || m_vis > 0 || m_sf)
      step(0, 0, m_ld > 0, m_loc > 0, m_vis > 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    live = 0;
    op_valid = 0; ld_done = 0; st_done = 0; st_vis = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    live = 1;
  endtask

  initial begin
    void'($urandom(32'h5EED));
    model_reset();
    do_reset();

    // R12: clean state after reset
    step(1, 2, 0, 0, 0);
    chk(op_ready == 1'b1, "R12", "full fence ready after reset", int'(op_ready), 1);
    chk(fence_retire == 1'b1, "R12", "full fence retire after reset", int'(fence_retire), 1);

    // R5 / R6 / R2: load fence ignores visibility, full fence does not
    step(1, 1, 0, 0, 0);
    step(1, 4, 0, 0, 0);
    chk(op_ready == 1'b0, "R5", "load fence held by local store", int'(op_ready), 0);
    step(1, 4, 0, 1, 0);
    chk(op_ready == 1'b1, "R6", "load fence ready with last local pulse", int'(op_ready), 1);
    chk(fence_retire == 1'b1 && fence_retire_kind == 3'd4, "R5", "load fence retire",
        int'(fence_retire_kind), 4);
    step(1, 2, 0, 0, 0);
    chk(op_ready == 1'b0, "R2", "full fence held by invisible store", int'(op_ready), 0);
    step(1, 2, 0, 0, 1);
    chk(op_ready == 1'b1 && fence_retire == 1'b1, "R2", "full fence retire on visibility",
        int'(fence_retire), 1);
    step(0, 0, 0, 0, 0);

    // R3 / R4 / R8: store fence in flight
    step(1, 1, 0, 0, 0);
    step(1, 3, 0, 0, 0);
    chk(op_ready == 1'b1 && fence_retire == 1'b0, "R3", "store fence parked",
        int'(fence_retire), 0);
    step(1, 0, 0, 0, 0);
    chk(op_ready == 1'b1 && mem_ld_issue == 1'b1, "R4", "load passes store fence",
        int'(mem_ld_issue), 1);
    step(1, 4, 0, 0, 0);
    chk(op_ready == 1'b0, "R8", "load fence behind store fence", int'(op_ready), 0);
    step(1, 1, 0, 1, 0);
    chk(op_ready == 1'b0, "R3", "store behind store fence", int'(op_ready), 0);
    step(1, 1, 0, 0, 1);
    chk(fence_retire == 1'b1 && fence_retire_kind == 3'd3, "R3", "store fence retire",
        int'(fence_retire_kind), 3);
    chk(op_ready == 1'b0, "R3", "store still held in retire cycle", int'(op_ready), 0);
    step(1, 1, 0, 0, 0);
    chk(op_ready == 1'b1, "R3", "store accepted after retire", int'(op_ready), 1);
    drain();

    // R9: no-op codes
    step(1, 6, 0, 0, 0);
    chk(op_ready == 1'b1 && !mem_ld_issue && !mem_st_issue && !fence_retire, "R9",
        "no-op accepted silently", int'(op_ready), 1);
    step(0, 0, 0, 0, 0);

    // R10: spurious pulses must not wrap the counts
    step(0, 0, 1, 1, 1);
    step(1, 1, 0, 0, 0);
    step(1, 2, 0, 0, 0);
    chk(op_ready == 1'b0, "R10", "full fence held after spurious pulses", int'(op_ready), 0);
    step(1, 2, 0, 1, 1);
    chk(op_ready == 1'b1, "R10", "full fence retires on real pulses", int'(op_ready), 1);
    step(0, 0, 0, 0, 0);

    // R11: outstanding load limit
    for (int i = 0; i < CMAX; i++) step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    chk(op_ready == 1'b0, "R11", "load held at limit", int'(op_ready), 0);
    step(1, 0, 1, 0, 0);
    chk(op_ready == 1'b0, "R11", "load held in freeing cycle", int'(op_ready), 0);
    step(1, 0, 0, 0, 0);
    chk(op_ready == 1'b1, "R11", "load accepted after free", int'(op_ready), 1);
    step(0, 0, 0, 0, 0);
    drain();

    // Random mix
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!op_valid || n_fire) begin
        op_valid = ($urandom % 4) != 0;
        op_type  = 3'(pick_type());
      end
      ld_done = ($urandom % 3) == 0;
      st_done = ($urandom % 3) == 0;
      st_vis  = ($urandom % 3) == 0;
    end
    step(0, 0, 0, 0, 0);
    drain();

    // R12: reset with counts and a store fence in flight
    step(1, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(1, 3, 0, 0, 0);
    do_reset();
    step(1, 2, 0, 0, 0);
    chk(op_ready == 1'b1 && fence_retire == 1'b1, "R12", "full fence after mid-run reset",
        int'(op_ready), 1);
    step(1, 1, 0, 0, 0);
    chk(op_ready == 1'b1, "R12", "store accepted after mid-run reset", int'(op_ready), 1);
    step(0, 0, 0, 0, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R12 watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule